// File: doc/BRIEF.md
# Serial Pattern Recognizer with Lockout

This block watches a serial bit stream, taking one bit on each rising clock edge. It raises its output for one cycle whenever the three most recent bits read 0, 1, 0. It does this only while the stream has never held the bits 1, 0, 0 since reset. When 1, 0, 0 appears, the block falls into a lockout state. It stays there for any input, and the output stays low until the next reset.

The design is a Moore machine. The output comes from a flop that is loaded from the decoded next state. The output for a sampled bit is therefore visible from the edge that sampled it until the next edge. It does not change between edges, whatever the input does.

The reset input is asynchronous and active low. Its release is synchronized inside the block. After the external reset rises, the machine ignores the input for `RST_STAGES` rising edges. The first bit it accepts is the one sampled on the following edge.

Top module: `pat_lock_detector`

## Requirements
- R1: While reset is active, and after its release until the first bit is accepted, `z_out` is 0 and the machine holds its initial state, with no partial match of either pattern.
- R2: After the edge that samples a bit completing the ordered triple 0,1,0 (oldest first), `z_out` is 1 until the next edge, provided 1,0,0 has not appeared since reset. For the stream 00101010010 the per-bit output is 00010101000, and for 11011010010 it is 00000001000.
- R3: Matches may overlap: the stream 0,1,0,1,0 produces two one-cycle pulses, separated by one low cycle.
- R4: From the edge that samples the third bit of 1,0,0 onward, `z_out` stays 0 for every later input until reset.
- R5: The lockout state is absorbing for input 0 and for input 1.
- R6: `z_out` changes only at rising clock edges. A change of `x_in` between edges does not affect it until the next edge.
- R7: `z_out` is never 1 on two consecutive sampled bits.
- R8: A reset applied during lockout restores detection. The same stream then produces the same output as after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one input bit is taken per edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | Registered match flag (Moore output) |

## Verification
A wrong state shows up at `z_out` within at most three sampled bits. A lost partial match either drops the pulse that follows 0,1,0 or raises one where there should be none. A missed lockout lets a pulse through after 1,0,0, which the reference model flags as soon as the stream next ends in 0,1,0. An escape from lockout is caught the same way. The bench therefore runs long pseudo-random streams in which both patterns occur often, and it compares every bit. It also toggles the input between edges to expose any path from `x_in` to the output that bypasses the clock.

// File: rtl/pat_lock_pkg.sv
package pat_lock_pkg;

  localparam int STATE_W = 3;

  // Each state names the recent history that still matters.
  typedef enum logic [STATE_W-1:0] {
    ST_START  = 3'd0, // nothing sampled yet
    ST_TAIL0  = 3'd1, // ends in 0, bit before was not 1
    ST_TAIL01 = 3'd2, // ends in 0,1
    ST_HIT    = 3'd3, // ends in 0,1,0 : output asserted
    ST_TAIL1  = 3'd4, // ends in 1, bit before was not 0
    ST_TAIL10 = 3'd5, // ends in 1,0 without a preceding 0
    ST_LOCK   = 3'd6  // 1,0,0 seen : absorbing
  } det_state_e;

endpackage

// File: rtl/pat_lock_rst_sync.sv
module pat_lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assertion is immediate; release is pipelined through STAGES flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pat_lock_next.sv
module pat_lock_next
  import pat_lock_pkg::*;
(
  input  det_state_e state_q,
  input  logic       x_in,
  output det_state_e state_d,
  output logic       z_d
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START:  state_d = x_in ? ST_TAIL1  : ST_TAIL0;
      ST_TAIL0:  state_d = x_in ? ST_TAIL01 : ST_TAIL0;
      ST_TAIL01: state_d = x_in ? ST_TAIL1  : ST_HIT;
      ST_HIT:    state_d = x_in ? ST_TAIL01 : ST_LOCK;
      ST_TAIL1:  state_d = x_in ? ST_TAIL1  : ST_TAIL10;
      ST_TAIL10: state_d = x_in ? ST_TAIL01 : ST_LOCK;
      ST_LOCK:   state_d = ST_LOCK;
      default:   state_d = ST_LOCK;
    endcase
  end

  // Moore decode of the state about to be entered.
  assign z_d = (state_d == ST_HIT);

endmodule

// File: rtl/pat_lock_regs.sv
module pat_lock_regs
  import pat_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_en,
  input  det_state_e state_d,
  input  logic       z_d,
  output det_state_e state_q,
  output logic       z_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      z_q     <= 1'b0;
    end else if (adv_en) begin
      state_q <= state_d;
      z_q     <= z_d;
    end
  end

endmodule

// File: rtl/pat_lock_detector.sv
module pat_lock_detector
  import pat_lock_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  output logic z_out
);

  logic       rst_sync_n;
  det_state_e state_q;
  det_state_e state_d;
  logic       z_d;
  logic       z_q;

  pat_lock_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pat_lock_next u_next (
    .state_q (state_q),
    .x_in    (x_in),
    .state_d (state_d),
    .z_d     (z_d)
  );

  // One bit per clock: the enable is permanently on.
  pat_lock_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv_en  (1'b1),
    .state_d (state_d),
    .z_d     (z_d),
    .state_q (state_q),
    .z_q     (z_q)
  );

  assign z_out = z_q;

endmodule

// File: rtl/pat_lock_detector_chk.sv
module pat_lock_detector_chk
  import pat_lock_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       x_in,
  input det_state_e state_q,
  input logic       z_out
);

  // A pulse needs the last three sampled bits to read 0,1,0.
  assert_hit_needs_010_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    z_out |-> (!$past(x_in) && $past(x_in, 2) && !$past(x_in, 3)));

  // Lockout keeps the output low.
  assert_lock_silent_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_LOCK) |-> !z_out);

  // Lockout is never left for either input value.
  assert_lock_absorbing_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_LOCK) |=> (state_q == ST_LOCK));

  // A pulse cannot repeat on the next bit.
  assert_no_double_pulse_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    z_out |=> !z_out);

  // A zero after a pulse completes 1,0,0 and must lock.
  assert_hit_then_zero_locks_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (z_out && !x_in) |=> (state_q == ST_LOCK));

endmodule

bind pat_lock_detector pat_lock_detector_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .x_in       (x_in),
  .state_q    (state_q),
  .z_out      (z_out)
);

// File: tb/tb_pat_lock_detector.sv
module tb_pat_lock_detector;

  localparam int CLK_PERIOD = 10;
  localparam int RST_STAGES = 2;
  localparam int WATCHDOG   = 100000;

  logic clk;
  logic rst_n;
  logic x_in;
  logic z_out;

  int n_tests;
  int n_fail;

  // Reference model: history of the last bits and a lockout flag.
  int hist;    // last three bits, newest in bit 0
  int n_bits;
  bit locked;
  bit exp_z;

  pat_lock_detector #(.RST_STAGES(RST_STAGES)) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .x_in  (x_in),
    .z_out (z_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge. Applies reset and returns at a falling edge,
  // ready for the first accepted bit.
  task automatic do_reset();
    rst_n = 1'b0;
    x_in  = 1'b0;
    repeat (2) @(negedge clk);
    check(z_out == 1'b0, "R1 reset", z_out, 0);
    rst_n = 1'b1;
    hist = 0; n_bits = 0; locked = 1'b0; exp_z = 1'b0;
    for (int i = 0; i < RST_STAGES; i++) begin
      x_in = ~x_in; // ignored while reset is still held internally
      @(negedge clk);
      check(z_out == 1'b0, "R1 release", z_out, 0);
    end
  endtask

  // Called at a falling edge. Drives one bit, lets the edge sample it, and
  // compares at the following falling edge.
  task automatic step(input bit b, input string req, input bit jiggle);
    bit prev;
    x_in = b;
    @(posedge clk);
    hist   = ((hist << 1) | int'(b)) & 7;
    n_bits = n_bits + 1;
    if (n_bits >= 3 && hist == 3'b100) locked = 1'b1;
    prev  = exp_z;
    exp_z = (n_bits >= 3) && (hist == 3'b010) && !locked;
    @(negedge clk);
    check(z_out == exp_z, req, z_out, exp_z);
    if (prev && exp_z) check(1'b0, "R7 model", 1, 0);
    if (jiggle) begin
      x_in = ~x_in;
      #(CLK_PERIOD/5);
      check(z_out == exp_z, "R6 between edges", z_out, exp_z);
    end
  endtask

  task automatic run_vec(input logic [10:0] bits, input logic [10:0] want, input string req);
    logic [10:0] got;
    for (int i = 10; i >= 0; i--) begin
      step(bits[i], req, 1'b0);
      got[i] = z_out;
    end
    check(got == want, req, got, want);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    x_in    = 1'b0;
    @(negedge clk);

    // R2: the two stated streams.
    do_reset();
    run_vec(11'b00101010010, 11'b00010101000, "R2 stream A");
    do_reset();
    run_vec(11'b11011010010, 11'b00000001000, "R2 stream B");

    // R3: overlapping matches, two pulses.
    do_reset();
    begin
      int pulses = 0;
      step(1'b0, "R3", 1'b0);
      step(1'b1, "R3", 1'b0);
      step(1'b0, "R3", 1'b0); pulses += int'(z_out);
      step(1'b1, "R3", 1'b0); check(z_out == 1'b0, "R3 gap", z_out, 0);
      step(1'b0, "R3", 1'b0); pulses += int'(z_out);
      check(pulses == 2, "R3 pulse count", pulses, 2);
    end

    // R4 / R5: lockout, then both input values, then 0,1,0 patterns.
    do_reset();
    step(1'b1, "R4", 1'b0);
    step(1'b0, "R4", 1'b0);
    step(1'b0, "R4", 1'b0);
    for (int i = 0; i < 12; i++) step(1'b1, "R5 input one", 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, "R5 input zero", 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(1'b1, "R4 stays low", 1'b0);
      step(1'b0, "R4 stays low", 1'b0);
      check(z_out == 1'b0, "R4 after 010", z_out, 0);
    end

    // R8: reset out of lockout restores detection.
    do_reset();
    run_vec(11'b00101010010, 11'b00010101000, "R8 after lockout");

    // R6: input toggled between edges.
    do_reset();
    step(1'b0, "R6", 1'b1);
    step(1'b1, "R6", 1'b1);
    step(1'b0, "R6", 1'b1);
    step(1'b1, "R6", 1'b1);
    step(1'b0, "R6", 1'b1);

    // R2/R4/R7: pseudo-random streams with many resets.
    lfsr = 16'hACE1;
    for (int r = 0; r < 40; r++) begin
      do_reset();
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] ^ lfsr[7], "R2 random", (i % 7) == 3);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule